// File: doc/BRIEF.md
# One-Wire Slot Timing Engine

This block runs the bit-level timing of a single open-drain one-wire bus. A controller above it hands over one command per operation: a write slot, a read slot, a bus reset with presence detection, or a combined "touch" that either reads or writes a zero depending on the supplied bit. The engine pulls the line low for the required interval, releases it, samples the line at a fixed point after release where the operation calls for it, and then holds off for the recovery time before it raises a one-cycle completion strobe together with the result bit.

All intervals are counted in microsecond ticks. A prescaler derives the ticks from the clock frequency parameter. A scale factor supplied with each command multiplies every interval of that command, so a slow bus can be served without changing the hardware. The line input passes through a two-stage synchroniser before it is sampled. The pad itself is outside the block: the engine only provides an enable that drives the line low.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, line_oe, busy and done are all 0.
- R2: cmd_op 2'b00 with cmd_bit 1 is a write-1 slot: the line is driven low for 6 µs × scale, and done rises 70 µs × scale after acceptance with result 0.
- R3: cmd_op 2'b00 with cmd_bit 0 is a write-0 slot: the line is driven low for 60 µs × scale, and done rises 70 µs × scale after acceptance with result 0.
- R4: cmd_op 2'b01 is a read slot: the line is driven low for 6 µs × scale, the synchronised line is sampled 9 µs × scale after release, and done rises 70 µs × scale after acceptance with result equal to the sampled level. Once released, the line is not driven again within the same command.
- R5: cmd_op 2'b10 is a bus reset: the line is driven low for 500 µs × scale, sampled 70 µs × scale after release, and done rises 1000 µs × scale after acceptance. Result 1 means the line was high (no device) and result 0 means a device held it low.
- R6: cmd_op 2'b11 is a touch: with cmd_bit 1 it behaves as the read slot of R4, with cmd_bit 0 as the write-0 slot of R3 and returns 0.
- R7: cmd_scale is captured when a command is accepted and multiplies every interval of that command; a value of 0 acts as 1.
- R8: busy is 1 from the cycle after acceptance until done is raised; done lasts exactly one cycle, and busy is 0 in that cycle. A command presented while busy is ignored: it neither alters the running slot nor starts another.
- R9: A command presented in the cycle where done is 1 is accepted, and the line is driven low from the next cycle.
- R10: One microsecond tick lasts CLK_HZ / 1,000,000 clock cycles, counted from the acceptance edge, and the line input reaches the sampling point through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle command strobe, taken when busy is 0 |
| cmd_op | input | 2 | Operation: 00 write, 01 read, 10 bus reset, 11 touch |
| cmd_bit | input | 1 | Bit to write, or touch selector |
| cmd_scale | input | SCALE_W | Interval multiplier for this command (0 acts as 1) |
| line_in | input | 1 | Level of the bus line (asynchronous) |
| line_oe | output | 1 | 1 drives the bus line low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_bit | output | 1 | Sampled level or presence result, valid with done |

## Verification
The completion of one command and the acceptance of the next can share a cycle: since done is raised in the cycle where the engine has already become idle, a new command presented then must start at once. The bench provokes this by waiting for done and issuing the next command in that same cycle, and judges it by the line being driven low and busy being high in the very next cycle, and by the second slot's full timing. The opposite overlap, a command arriving while a slot is running, is provoked mid-slot and judged by the running slot keeping its exact timing and by no extra start or done appearing afterwards.

// File: rtl/owire_pkg.sv
package owire_pkg;

  // Base slot intervals in microseconds
  localparam int unsigned US_W1_LOW   = 6;
  localparam int unsigned US_W1_REST  = 64;
  localparam int unsigned US_W0_LOW   = 60;
  localparam int unsigned US_W0_REST  = 10;
  localparam int unsigned US_RD_LOW   = 6;
  localparam int unsigned US_RD_WAIT  = 9;
  localparam int unsigned US_RD_TAIL  = 55;
  localparam int unsigned US_RST_LOW  = 500;
  localparam int unsigned US_RST_WAIT = 70;
  localparam int unsigned US_RST_TAIL = 430;
  localparam int unsigned US_LONGEST  = 500;
  localparam int unsigned US_PER_SEC  = 1_000_000;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_RESET = 2'b10,
    OP_TOUCH = 2'b11
  } owire_op_e;

  typedef enum logic [1:0] {
    SLOT_W1,
    SLOT_W0,
    SLOT_RD,
    SLOT_RST
  } slot_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_GAP,
    PH_TAIL
  } slot_phase_e;

  typedef struct packed {
    logic [9:0] low_us;
    logic [9:0] gap_us;
    logic [9:0] tail_us;
    logic       sample;
  } slot_plan_t;

  function automatic slot_plan_t plan_for(slot_kind_e kind);
    slot_plan_t p;
    p = '0;
    case (kind)
      SLOT_W1: begin
        p.low_us = 10'(US_W1_LOW);
        p.gap_us = 10'(US_W1_REST);
      end
      SLOT_W0: begin
        p.low_us = 10'(US_W0_LOW);
        p.gap_us = 10'(US_W0_REST);
      end
      SLOT_RD: begin
        p.low_us  = 10'(US_RD_LOW);
        p.gap_us  = 10'(US_RD_WAIT);
        p.tail_us = 10'(US_RD_TAIL);
        p.sample  = 1'b1;
      end
      default: begin
        p.low_us  = 10'(US_RST_LOW);
        p.gap_us  = 10'(US_RST_WAIT);
        p.tail_us = 10'(US_RST_TAIL);
        p.sample  = 1'b1;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/owire_tick_gen.sv
module owire_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_every_cycle
      logic unused_tick_ins;
      assign unused_tick_ins = ^{clk, rst_n, restart};
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (restart) begin
          cnt_d = '0;
        end else if (cnt_q == LAST) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d};
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/owire_slot_decode.sv
module owire_slot_decode
  import owire_pkg::*;
#(
  parameter int unsigned SCALE_W = 4,
  parameter int unsigned LEN_W   = 13
) (
  input  owire_op_e          op,
  input  logic               op_bit,
  input  logic [SCALE_W-1:0] scale,
  output logic [LEN_W-1:0]   low_len,
  output logic [LEN_W-1:0]   gap_len,
  output logic [LEN_W-1:0]   tail_len,
  output logic               do_sample
);

  slot_kind_e         kind;
  slot_plan_t         plan;
  logic [SCALE_W-1:0] eff_scale;

  always_comb begin
    unique case (op)
      OP_WRITE: kind = op_bit ? SLOT_W1 : SLOT_W0;
      OP_READ:  kind = SLOT_RD;
      OP_RESET: kind = SLOT_RST;
      OP_TOUCH: kind = op_bit ? SLOT_RD : SLOT_W0;
      default:  kind = SLOT_RST;
    endcase
  end

  assign plan      = plan_for(kind);
  assign eff_scale = (scale == '0) ? SCALE_W'(1) : scale;

  assign low_len   = LEN_W'(int'(plan.low_us)  * int'(eff_scale));
  assign gap_len   = LEN_W'(int'(plan.gap_us)  * int'(eff_scale));
  assign tail_len  = LEN_W'(int'(plan.tail_us) * int'(eff_scale));
  assign do_sample = plan.sample;

endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int unsigned LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             tick,
  input  logic             line_s,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] gap_len,
  input  logic [LEN_W-1:0] tail_len,
  input  logic             do_sample,
  output logic             accept,
  output logic             line_oe,
  output logic             busy,
  output logic             done,
  output logic             result
);

  slot_phase_e      ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] low_q, low_d;
  logic [LEN_W-1:0] gap_q, gap_d;
  logic [LEN_W-1:0] tail_q, tail_d;
  logic             smp_q, smp_d;
  logic             oe_q, oe_d;
  logic             done_q, done_d;
  logic             bit_q, bit_d;
  logic             res_q, res_d;
  logic [LEN_W-1:0] cur_len;
  logic             at_end;

  always_comb begin
    unique case (ph_q)
      PH_LOW:  cur_len = low_q;
      PH_GAP:  cur_len = gap_q;
      default: cur_len = tail_q;
    endcase
  end

  assign at_end = tick && (cnt_q == (cur_len - 1'b1));
  assign accept = cmd_valid && (ph_q == PH_IDLE);

  // Next-state logic
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    low_d  = low_q;
    gap_d  = gap_q;
    tail_d = tail_q;
    smp_d  = smp_q;
    oe_d   = oe_q;
    bit_d  = bit_q;
    res_d  = res_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d   = PH_LOW;
          cnt_d  = '0;
          low_d  = low_len;
          gap_d  = gap_len;
          tail_d = tail_len;
          smp_d  = do_sample;
          oe_d   = 1'b1;
          bit_d  = 1'b0;
        end
      end
      PH_LOW: begin
        if (at_end) begin
          ph_d  = PH_GAP;
          cnt_d = '0;
          oe_d  = 1'b0;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_GAP: begin
        if (at_end) begin
          cnt_d = '0;
          if (smp_q) begin
            bit_d = line_s;
            ph_d  = PH_TAIL;
          end else begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
            res_d  = 1'b0;
          end
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_TAIL: begin
        if (at_end) begin
          cnt_d  = '0;
          ph_d   = PH_IDLE;
          done_d = 1'b1;
          res_d  = bit_q;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      low_q  <= '0;
      gap_q  <= '0;
      tail_q <= '0;
      smp_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      low_q  <= low_d;
      gap_q  <= gap_d;
      tail_q <= tail_d;
      smp_q  <= smp_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      bit_q  <= bit_d;
      res_q  <= res_d;
    end
  end

  assign line_oe = oe_q;
  assign busy    = (ph_q != PH_IDLE);
  assign done    = done_q;
  assign result  = res_q;

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owire_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SCALE_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_bit,
  input  logic [SCALE_W-1:0] cmd_scale,
  input  logic               line_in,
  output logic               line_oe,
  output logic               busy,
  output logic               done,
  output logic               rd_bit
);

  localparam int unsigned TICK_DIV  = CLK_HZ / US_PER_SEC;
  localparam int unsigned SCALE_MAX = (1 << SCALE_W) - 1;
  localparam int unsigned LEN_W     = $clog2(US_LONGEST * SCALE_MAX + 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             tick;
  logic             line_s;
  logic             accept;
  logic [LEN_W-1:0] low_len, gap_len, tail_len;
  logic             do_sample;

  // Reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  owire_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (accept),
    .tick    (tick)
  );

  owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (line_in),
    .q     (line_s)
  );

  owire_slot_decode #(.SCALE_W(SCALE_W), .LEN_W(LEN_W)) u_dec (
    .op        (owire_op_e'(cmd_op)),
    .op_bit    (cmd_bit),
    .scale     (cmd_scale),
    .low_len   (low_len),
    .gap_len   (gap_len),
    .tail_len  (tail_len),
    .do_sample (do_sample)
  );

  owire_slot_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .tick      (tick),
    .line_s    (line_s),
    .low_len   (low_len),
    .gap_len   (gap_len),
    .tail_len  (tail_len),
    .do_sample (do_sample),
    .accept    (accept),
    .line_oe   (line_oe),
    .busy      (busy),
    .done      (done),
    .result    (rd_bit)
  );

endmodule

// File: rtl/owire_slot_checker.sv
module owire_slot_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic line_oe,
  input logic rd_bit
);

  // R8: completion strobe is a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: busy only ends through a completion
  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2: the line is only driven while a command runs
  p_drive_in_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);

  // R9: an accepted command drives the line low in the next cycle
  p_accept_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> (busy && line_oe));

  // R4: once released, the line stays released until the command ends
  p_no_redrive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !line_oe) |=> !line_oe);

  // R4: result only changes together with the completion strobe
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_bit));

endmodule

bind owire_slot_engine owire_slot_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .line_oe   (line_oe),
  .rd_bit    (rd_bit)
);

// File: tb/sim_owire_slot_engine.sv
module sim_owire_slot_engine;

  localparam int unsigned CLK_HZ  = 4_000_000;
  localparam int          DIV     = 4;
  localparam int unsigned SCALE_W = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmd_valid = 1'b0;
  logic [1:0]         cmd_op = 2'b00;
  logic               cmd_bit = 1'b0;
  logic [SCALE_W-1:0] cmd_scale = '0;
  logic               line_in;
  logic               line_oe, busy, done, rd_bit;

  logic resp_low = 1'b0;
  logic win_en   = 1'b0;
  logic win_low  = 1'b0;
  int   win_lo   = 0;
  int   win_hi   = 0;

  always #5 clk = ~clk;

  assign line_in = !(line_oe || resp_low || win_low);

  owire_slot_engine #(.CLK_HZ(CLK_HZ), .SCALE_W(SCALE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .cmd_scale(cmd_scale), .line_in(line_in),
    .line_oe(line_oe), .busy(busy), .done(done), .rd_bit(rd_bit)
  );

  typedef struct {
    int    low_cyc;
    int    tot_cyc;
    bit    res;
    string req;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   active = 0;
  bit   busy_prev = 0;
  int   k = 0;
  int   lowc = 0;

  task automatic chk(bit ok, string req, string what, int got, int want);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
    end
  endtask

  function automatic exp_t predict(logic [1:0] op, bit b, bit res_rd, int scale, string req);
    exp_t e;
    int s;
    bit rd_like;
    s = (scale == 0) ? 1 : scale;
    rd_like = (op == 2'b01) || (op == 2'b11 && b);
    if (op == 2'b10) begin
      e.low_cyc = 500 * s * DIV;
      e.tot_cyc = 1000 * s * DIV + 1;
      e.res = res_rd;
    end else if (rd_like) begin
      e.low_cyc = 6 * s * DIV;
      e.tot_cyc = 70 * s * DIV + 1;
      e.res = res_rd;
    end else begin
      e.low_cyc = ((op == 2'b00 && b) ? 6 : 60) * s * DIV;
      e.tot_cyc = 70 * s * DIV + 1;
      e.res = 1'b0;
    end
    e.req = req;
    return e;
  endfunction

  // Drive one command at the first idle cycle; push its expected outcome
  task automatic send(logic [1:0] op, bit b, bit resp, bit we, int wlo, int whi,
                      int scale, bit res_rd, string req);
    @(negedge clk);
    while (busy) @(negedge clk);
    #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b; cmd_scale = SCALE_W'(scale);
    resp_low = resp; win_en = we; win_lo = wlo; win_hi = whi;
    exp_q.push_back(predict(op, b, res_rd, scale, req));
    @(negedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_prev) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected start", 1, 0);
          active = 0;
        end else begin
          cur = exp_q.pop_front();
          active = 1;
        end
        k = 1;
        lowc = line_oe ? 1 : 0;
      end else if (active) begin
        k++;
        if (line_oe) lowc++;
        if (done) begin
          chk(lowc == cur.low_cyc, cur.req, "low cycles", lowc, cur.low_cyc);
          chk(k == cur.tot_cyc, cur.req, "cycles to done", k, cur.tot_cyc);
          chk(rd_bit == cur.res, cur.req, "result", int'(rd_bit), int'(cur.res));
          active = 0;
        end
      end else if (done) begin
        chk(0, "R8", "unexpected done", 1, 0);
      end
      win_low = win_en && active && (k >= win_lo) && (k <= win_hi);
      busy_prev = busy;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(line_oe == 1'b0, "R1", "line_oe in reset", int'(line_oe), 0);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(line_oe == 1'b0 && busy == 1'b0, "R1", "idle after reset", int'(busy), 0);

    // R5: reset with device present, then absent
    send(2'b10, 0, 1, 0, 0, 0, 1, 0, "R5");
    send(2'b10, 0, 0, 0, 0, 0, 1, 1, "R5");
    // R2 / R3: write slots
    send(2'b00, 1, 0, 0, 0, 0, 1, 0, "R2");
    send(2'b00, 0, 0, 0, 0, 0, 1, 0, "R3");
    // R4: read slots, both levels
    send(2'b01, 0, 1, 0, 0, 0, 1, 0, "R4");
    send(2'b01, 0, 0, 0, 0, 0, 1, 1, "R4");
    // R6: touch both ways (bit 0 returns 0 even on a high line)
    send(2'b11, 1, 1, 0, 0, 0, 1, 0, "R6");
    send(2'b11, 0, 0, 0, 0, 0, 1, 0, "R6");
    // R7: scaled intervals, and scale 0 acting as 1
    send(2'b00, 0, 0, 0, 0, 0, 3, 0, "R7");
    send(2'b10, 0, 1, 0, 0, 0, 2, 0, "R7");
    send(2'b01, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R10: sample point; line state two flops ahead of the 15 us point
    send(2'b01, 0, 0, 1, 52, 58, 1, 0, "R10");
    send(2'b01, 0, 0, 1, 59, 75, 1, 1, "R10");

    // R8: command while busy is ignored
    send(2'b01, 0, 0, 0, 0, 0, 1, 1, "R8");
    repeat (20) @(negedge clk);
    #1;
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_scale = SCALE_W'(5);
    @(negedge clk);
    #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after ignored command", int'(busy), 0);
    chk(line_oe == 1'b0, "R8", "line after ignored command", int'(line_oe), 0);

    // R9: next command issued in the done cycle
    send(2'b00, 1, 0, 0, 0, 0, 1, 0, "R9");
    @(negedge clk);
    while (!done) @(negedge clk);
    #1;
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_bit = 1'b0; cmd_scale = SCALE_W'(1);
    exp_q.push_back(predict(2'b00, 0, 0, 1, "R9"));
    @(negedge clk);
    chk(busy && line_oe, "R9", "started after done cycle", int'(busy && line_oe), 1);
    #1;
    cmd_valid = 1'b0;

    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule